// File: doc/BRIEF.md
# Branch and Interrupt Sequencer

This block decides where the processor fetches next. Each time an instruction finishes, the decoder raises a one-cycle step strobe and supplies the decoded control-transfer fields. These are whether the instruction is a branch, whether it jumps through a register or by a word offset, whether it links, and its four-bit condition code. The decoder also supplies the register operand and the current arithmetic flags. The sequencer tests the condition against the flags and picks the next program counter. When a branch with link is taken, it offers the return address for the link register.

The same block owns the interrupt state: an enable bit, a handler-active bit and one shadow register that holds a program counter together with its four flags. A request seen at a step while interrupts are enabled and no handler is active preempts the instruction at that boundary. The block saves that instruction's address and the flags, then jumps to a fixed vector. A return instruction restores both the address and the flags. Separate set and clear instructions write the enable bit.

Top module: `brctl_unit`

## Requirements
- R1: After reset the program counter is 0, the enable and handler-active bits are 0, and the shadow register holds address 0 with flags 0. A return issued straight after reset therefore yields address 0 and flags 0.
- R2: `flags_in` is ordered {N,Z,C,V} in bits 3..0. Condition bits 2:0 pick a predicate: 0 N, 1 Z, 2 C, 3 V, 4 C or Z, 5 N xor V, 6 (N xor V) or Z, 7 true. Condition bit 3 inverts the predicate, so code 15 is never taken. `taken` shows the result during the step cycle.
- R3: A taken register-target branch loads the register operand with bits 1:0 forced to zero.
- R4: A taken offset branch loads PC + 4 + 4 × offset, where the 24-bit offset is signed and the sum wraps modulo 2^32.
- R5: A step that is not a taken branch, return or interrupt entry advances the PC by 4.
- R6: `link_we` is high in a step cycle only for a taken branch with its link bit set, and `link_val` is then PC + 4.
- R7: Interrupt entry happens on a step with `irq_req` high, enable 1 and no active handler. It pulses `irq_taken`, saves the current PC and `flags_in`, and sets the next PC to 4. The instruction at that boundary has no effect: no branch, no link, no enable write.
- R8: Entry clears the enable bit and sets handler-active. A request is ignored when enable is 0 or a handler is active, even after a set-enable instruction inside the handler.
- R9: A return pulses `flags_restore_we` with the saved flags on `flags_restore_val`, reloads the saved PC, sets enable to 1 and clears handler-active.
- R10: An enable-write instruction copies `ien_bit` into the enable bit and advances the PC by 4.
- R11: While `step` is 0, the PC and interrupt state hold and no strobe (`taken`, `link_we`, `irq_taken`, `flags_restore_we`) is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | An instruction boundary: decoded fields are valid this cycle |
| is_branch | input | 1 | Instruction is a conditional branch |
| use_reg | input | 1 | Branch target comes from `rc_val` instead of the offset |
| link | input | 1 | Branch writes the return address on success |
| cond | input | 4 | Branch condition code |
| offset | input | 24 | Signed word offset for offset branches |
| rc_val | input | 32 | Register operand for register-target branches |
| is_rti | input | 1 | Return-from-interrupt instruction |
| is_ien | input | 1 | Enable-write instruction |
| ien_bit | input | 1 | New enable value for an enable-write instruction |
| irq_req | input | 1 | Interrupt request level |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| pc | output | 32 | Current program counter |
| taken | output | 1 | Branch condition met on this step |
| link_we | output | 1 | Write `link_val` to the link register |
| link_val | output | 32 | Return address PC + 4 |
| irq_taken | output | 1 | Interrupt entered on this step |
| irq_en | output | 1 | Interrupt enable bit |
| in_handler | output | 1 | A handler is active |
| flags_restore_we | output | 1 | Load the flags from `flags_restore_val` |
| flags_restore_val | output | 4 | Saved flags {N,Z,C,V} |

## Verification
The hardest case to reach is a request arriving inside a handler that has set its own enable bit again. In that state only the handler-active bit keeps the request out. The bench gets there by first taking an interrupt with a branch-with-link decoded on the same boundary, which shows that the preempted instruction is discarded. Inside the handler it issues a set-enable and then asserts the request again. It then returns and confirms that the flags and the address saved at entry come back, not values from later steps. The condition table is swept across all 16 codes and all 16 flag patterns, with register targets whose low bits are set.

// File: rtl/brctl_pkg.sv
package brctl_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   typedef enum logic [1:0] {
      SEL_SEQ   = 2'd0,
      SEL_JUMP  = 2'd1,
      SEL_ENTER = 2'd2,
      SEL_LEAVE = 2'd3
   } pc_sel_e;

endpackage

// File: rtl/brctl_cond.sv
module brctl_cond
   import brctl_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  flags_t            fl,
   input  logic [CODE_W-1:0] code,
   output logic              hold
);
   localparam int BASE_N = 1 << (CODE_W - 1);
   localparam int TAB_N  = 1 << CODE_W;

   logic [BASE_N-1:0] base;
   logic [TAB_N-1:0]  pred;

   always_comb begin
      base    = '0;
      base[0] = fl.n;
      base[1] = fl.z;
      base[2] = fl.c;
      base[3] = fl.v;
      base[4] = fl.c | fl.z;
      base[5] = fl.n ^ fl.v;
      base[6] = (fl.n ^ fl.v) | fl.z;
      base[7] = 1'b1;
   end

   // Upper half of the table is the complement of the lower half.
   for (genvar g = 0; g < BASE_N; g++) begin : g_tab
      assign pred[g]          = base[g];
      assign pred[g + BASE_N] = ~base[g];
   end

   assign hold = pred[code];

endmodule

// File: rtl/brctl_target.sv
module brctl_target #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 24
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  rc_val,
   input  logic [OFF_W-1:0] off,
   input  logic             use_reg,
   output logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  tgt
);
   localparam int EXT = XLEN - OFF_W - 2;

   logic [XLEN-1:0] disp;

   if (EXT > 0) begin : g_ext
      assign disp = {{EXT{off[OFF_W-1]}}, off, 2'b00};
   end else begin : g_noext
      assign disp = {off, 2'b00};
   end

   assign seq_pc = pc + XLEN'(4);
   assign tgt    = use_reg ? {rc_val[XLEN-1:2], 2'b00} : seq_pc + disp;

endmodule

// File: rtl/brctl_irq.sv
module brctl_irq
   import brctl_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            irq_req,
   input  logic            is_rti,
   input  logic            is_ien,
   input  logic            ien_bit,
   input  logic [XLEN-1:0] pc,
   input  flags_t          fl,
   output logic            irq_en,
   output logic            active,
   output logic            enter,
   output logic            leave,
   output logic [XLEN-1:0] shadow_pc,
   output flags_t          shadow_fl
);
   logic ien_wr;

   assign enter  = step & irq_req & irq_en & ~active;
   assign leave  = step & is_rti & ~enter;
   assign ien_wr = step & is_ien & ~is_rti & ~enter;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en    <= 1'b0;
         active    <= 1'b0;
         shadow_pc <= '0;
         shadow_fl <= '0;
      end else if (enter) begin
         shadow_pc <= pc;
         shadow_fl <= fl;
         irq_en    <= 1'b0;
         active    <= 1'b1;
      end else if (leave) begin
         irq_en    <= 1'b1;
         active    <= 1'b0;
      end else if (ien_wr) begin
         irq_en    <= ien_bit;
      end
   end

endmodule

// File: rtl/brctl_unit.sv
module brctl_unit
   import brctl_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              OFF_W    = 24,
   parameter int              CODE_W   = 4,
   parameter logic [XLEN-1:0] VECTOR   = 32'h0000_0004,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              is_branch,
   input  logic              use_reg,
   input  logic              link,
   input  logic [CODE_W-1:0] cond,
   input  logic [OFF_W-1:0]  offset,
   input  logic [XLEN-1:0]   rc_val,
   input  logic              is_rti,
   input  logic              is_ien,
   input  logic              ien_bit,
   input  logic              irq_req,
   input  logic [3:0]        flags_in,
   output logic [XLEN-1:0]   pc,
   output logic              taken,
   output logic              link_we,
   output logic [XLEN-1:0]   link_val,
   output logic              irq_taken,
   output logic              irq_en,
   output logic              in_handler,
   output logic              flags_restore_we,
   output logic [3:0]        flags_restore_val
);
   if (OFF_W < 1 || XLEN < OFF_W + 2) begin : g_bad_width
      $error("brctl_unit: XLEN must hold OFF_W plus two alignment bits");
   end
   if (CODE_W != 4) begin : g_bad_code
      $error("brctl_unit: condition table is defined for 4-bit codes");
   end
   if (VECTOR[1:0] != 2'b00 || RESET_PC[1:0] != 2'b00) begin : g_bad_align
      $error("brctl_unit: vector and reset address must be word aligned");
   end

   flags_t          fl;
   flags_t          sh_fl;
   logic            cond_ok;
   logic            enter;
   logic            leave;
   logic            br_go;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] tgt;
   logic [XLEN-1:0] sh_pc;
   logic [XLEN-1:0] pc_nxt;
   pc_sel_e         sel;

   assign fl = flags_in;

   brctl_cond #(.CODE_W(CODE_W)) u_cond (
      .fl   (fl),
      .code (cond),
      .hold (cond_ok)
   );

   brctl_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
      .pc      (pc),
      .rc_val  (rc_val),
      .off     (offset),
      .use_reg (use_reg),
      .seq_pc  (seq_pc),
      .tgt     (tgt)
   );

   brctl_irq #(.XLEN(XLEN)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .irq_req   (irq_req),
      .is_rti    (is_rti),
      .is_ien    (is_ien),
      .ien_bit   (ien_bit),
      .pc        (pc),
      .fl        (fl),
      .irq_en    (irq_en),
      .active    (in_handler),
      .enter     (enter),
      .leave     (leave),
      .shadow_pc (sh_pc),
      .shadow_fl (sh_fl)
   );

   assign br_go = step & is_branch & ~is_rti & ~is_ien & ~enter & cond_ok;

   always_comb begin
      if (enter)      sel = SEL_ENTER;
      else if (leave) sel = SEL_LEAVE;
      else if (br_go) sel = SEL_JUMP;
      else            sel = SEL_SEQ;
   end

   always_comb begin
      unique case (sel)
         SEL_ENTER: pc_nxt = VECTOR;
         SEL_LEAVE: pc_nxt = sh_pc;
         SEL_JUMP:  pc_nxt = tgt;
         default:   pc_nxt = seq_pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pc <= RESET_PC;
      else if (step) pc <= pc_nxt;
   end

   assign taken             = br_go;
   assign link_we           = br_go & link;
   assign link_val          = seq_pc;
   assign irq_taken         = enter;
   assign flags_restore_we  = leave;
   assign flags_restore_val = sh_fl;

endmodule

// File: rtl/brctl_check.sv
module brctl_check #(
   parameter int              XLEN   = 32,
   parameter int              CODE_W = 4,
   parameter logic [XLEN-1:0] VECTOR = 32'h0000_0004
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic              is_branch,
   input logic              use_reg,
   input logic              link,
   input logic [CODE_W-1:0] cond,
   input logic [3:0]        flags_in,
   input logic [XLEN-1:0]   pc,
   input logic              taken,
   input logic              link_we,
   input logic              irq_taken,
   input logic              irq_en,
   input logic              in_handler,
   input logic              flags_restore_we,
   input logic [3:0]        flags_restore_val
);
   // Independent model of what the shadow register should hold.
   logic [XLEN-1:0] m_pc;
   logic [3:0]      m_fl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_pc <= '0;
         m_fl <= '0;
      end else if (irq_taken) begin
         m_pc <= pc;
         m_fl <= flags_in;
      end
   end

   assert_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_branch && cond == '1) |-> !taken);

   assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && use_reg) |=> pc[1:0] == 2'b00);

   assert_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (taken && link && step));

   assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |=> pc == VECTOR);

   assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en || in_handler) |-> !irq_taken);

   assert_enter_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |=> (!irq_en && in_handler));

   assert_restore_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags_restore_we |-> flags_restore_val == m_fl);

   assert_restore_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flags_restore_we |=> (pc == m_pc && irq_en && !in_handler));

   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(pc) && $stable(irq_en) && $stable(in_handler)));

   assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !step |-> !(taken || link_we || irq_taken || flags_restore_we));

endmodule

bind brctl_unit brctl_check #(.XLEN(XLEN), .CODE_W(CODE_W), .VECTOR(VECTOR)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .step              (step),
   .is_branch         (is_branch),
   .use_reg           (use_reg),
   .link              (link),
   .cond              (cond),
   .flags_in          (flags_in),
   .pc                (pc),
   .taken             (taken),
   .link_we           (link_we),
   .irq_taken         (irq_taken),
   .irq_en            (irq_en),
   .in_handler        (in_handler),
   .flags_restore_we  (flags_restore_we),
   .flags_restore_val (flags_restore_val)
);

// File: tb/brctl_unit_test.sv
`timescale 1ns/1ps
module brctl_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic        is_branch = 1'b0, use_reg = 1'b0, link = 1'b0;
   logic [3:0]  cond = '0;
   logic [23:0] offset = '0;
   logic [31:0] rc_val = '0;
   logic        is_rti = 1'b0, is_ien = 1'b0, ien_bit = 1'b0, irq_req = 1'b0;
   logic [3:0]  flags_in = '0;
   logic [31:0] pc, link_val;
   logic        taken, link_we, irq_taken, irq_en, in_handler, flags_restore_we;
   logic [3:0]  flags_restore_val;

   int checks = 0;
   int errors = 0;

   logic        s_taken, s_lwe, s_irq, s_frw;
   logic [31:0] s_lval;
   logic [3:0]  s_frv;
   logic [31:0] exp_pc;
   logic [31:0] saved_pc;

   always #2 clk = ~clk;

   brctl_unit uut (
      .clk(clk), .rst_n(rst_n), .step(step), .is_branch(is_branch),
      .use_reg(use_reg), .link(link), .cond(cond), .offset(offset),
      .rc_val(rc_val), .is_rti(is_rti), .is_ien(is_ien), .ien_bit(ien_bit),
      .irq_req(irq_req), .flags_in(flags_in), .pc(pc), .taken(taken),
      .link_we(link_we), .link_val(link_val), .irq_taken(irq_taken),
      .irq_en(irq_en), .in_handler(in_handler),
      .flags_restore_we(flags_restore_we), .flags_restore_val(flags_restore_val)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic pred(input logic [3:0] c, input logic [3:0] f);
      logic n, z, cy, v, r;
      n = f[3]; z = f[2]; cy = f[1]; v = f[0];
      case (c[2:0])
         3'd0: r = n;
         3'd1: r = z;
         3'd2: r = cy;
         3'd3: r = v;
         3'd4: r = cy | z;
         3'd5: r = n ^ v;
         3'd6: r = (n ^ v) | z;
         default: r = 1'b1;
      endcase
      return r ^ c[3];
   endfunction

   // Drive one step at a falling edge, capture the combinational strobes,
   // then let the rising edge register the result and return idle.
   task automatic op(input logic br, input logic ur, input logic lk, input logic [3:0] cc,
                     input logic [23:0] off, input logic [31:0] rc, input logic rt,
                     input logic ie, input logic eb, input logic rq, input logic [3:0] fl);
      @(negedge clk);
      step = 1'b1; is_branch = br; use_reg = ur; link = lk; cond = cc;
      offset = off; rc_val = rc; is_rti = rt; is_ien = ie; ien_bit = eb;
      irq_req = rq; flags_in = fl;
      #1;
      s_taken = taken; s_lwe = link_we; s_lval = link_val;
      s_irq = irq_taken; s_frw = flags_restore_we; s_frv = flags_restore_val;
      @(negedge clk);
      step = 1'b0; is_branch = 1'b0; is_rti = 1'b0; is_ien = 1'b0;
      irq_req = 1'b0; link = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 pc", pc, 32'h0);
      chk("R1 irq_en", {31'd0, irq_en}, 32'd0);
      chk("R1 in_handler", {31'd0, in_handler}, 32'd0);

      // Return straight after reset: shadow is cleared.
      op(0,0,0,4'h0,24'h0,32'h0, 1,0,0, 0, 4'hF);
      chk("R1 R9 restore_we", {31'd0, s_frw}, 32'd1);
      chk("R1 R9 restore flags", {28'd0, s_frv}, 32'd0);
      chk("R1 R9 pc", pc, 32'h0);
      chk("R9 irq_en set", {31'd0, irq_en}, 32'd1);
      // Clear enable: R10
      op(0,0,0,4'h0,24'h0,32'h0, 0,1,0, 0, 4'h0);
      chk("R10 clear", {31'd0, irq_en}, 32'd0);
      chk("R10 pc", pc, 32'h4);
      exp_pc = 32'h4;

      // R2 / R3 / R5: full condition sweep with register targets.
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            logic [31:0] rc;
            logic        t;
            rc = 32'h0000_1000 + 32'((c * 16 + f) * 8) + 32'h3;
            t  = pred(4'(c), 4'(f));
            op(1,1,0,4'(c),24'h0,rc, 0,0,0, 0, 4'(f));
            chk("R2 taken", {31'd0, s_taken}, {31'd0, t});
            exp_pc = t ? {rc[31:2], 2'b00} : exp_pc + 32'd4;
            chk("R3 R5 pc", pc, exp_pc);
         end
      end

      // R4: offset branches, always condition.
      op(1,1,0,4'h7,24'h0,32'h0000_1000, 0,0,0, 0, 4'h0);
      exp_pc = 32'h1000;
      chk("R3 setup", pc, exp_pc);
      begin
         logic [23:0] offs [6];
         offs[0] = 24'h000000; offs[1] = 24'h000001; offs[2] = 24'hFFFFFF;
         offs[3] = 24'h7FFFFF; offs[4] = 24'h800000; offs[5] = 24'h123456;
         for (int i = 0; i < 6; i++) begin
            op(1,0,0,4'h7,offs[i],32'hFFFF_FFFF, 0,0,0, 0, 4'h0);
            exp_pc = exp_pc + 32'd4 + ({{8{offs[i][23]}}, offs[i]} << 2);
            chk("R4 offset pc", pc, exp_pc);
         end
      end

      // R6: link behaviour.
      op(1,0,1,4'h7,24'h000010,32'h0, 0,0,0, 0, 4'h0);
      chk("R6 link_we", {31'd0, s_lwe}, 32'd1);
      chk("R6 link_val", s_lval, exp_pc + 32'd4);
      exp_pc = exp_pc + 32'd4 + 32'h40;
      chk("R6 pc", pc, exp_pc);
      op(1,0,1,4'hF,24'h000010,32'h0, 0,0,0, 0, 4'h0);
      chk("R6 no link when not taken", {31'd0, s_lwe}, 32'd0);
      exp_pc = exp_pc + 32'd4;
      op(1,0,0,4'h7,24'h000000,32'h0, 0,0,0, 0, 4'h0);
      chk("R6 no link without bit", {31'd0, s_lwe}, 32'd0);
      exp_pc = exp_pc + 32'd4;
      // R5: plain step.
      op(0,0,0,4'h7,24'h000100,32'h0, 0,0,0, 0, 4'h0);
      exp_pc = exp_pc + 32'd4;
      chk("R5 plain step", pc, exp_pc);

      // R11: no step, everything held.
      @(negedge clk);
      is_branch = 1'b1; use_reg = 1'b1; link = 1'b1; cond = 4'h7;
      rc_val = 32'h8000; is_rti = 1'b1; irq_req = 1'b1;
      #1;
      chk("R11 no strobes", {28'd0, taken, link_we, irq_taken, flags_restore_we}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R11 pc held", pc, exp_pc);
      chk("R11 handler held", {30'd0, irq_en, in_handler}, 32'd0);
      is_branch = 1'b0; link = 1'b0; is_rti = 1'b0; irq_req = 1'b0;

      // R8: request with enable low is ignored.
      op(0,0,0,4'h0,24'h0,32'h0, 0,0,0, 1, 4'h0);
      exp_pc = exp_pc + 32'd4;
      chk("R8 ignored when disabled", {31'd0, s_irq}, 32'd0);
      chk("R8 pc", pc, exp_pc);
      // R10: set enable.
      op(0,0,0,4'h0,24'h0,32'h0, 0,1,1, 0, 4'h0);
      exp_pc = exp_pc + 32'd4;
      chk("R10 set", {31'd0, irq_en}, 32'd1);

      // R7: entry preempts a branch-with-link.
      saved_pc = exp_pc;
      op(1,1,1,4'h7,24'h0,32'h0000_9000, 0,0,0, 1, 4'hA);
      chk("R7 irq_taken", {31'd0, s_irq}, 32'd1);
      chk("R7 no link", {31'd0, s_lwe}, 32'd0);
      chk("R7 vector", pc, 32'h4);
      chk("R8 state", {30'd0, irq_en, in_handler}, 32'd1);
      // Inside handler: set enable then request is still ignored.
      op(0,0,0,4'h0,24'h0,32'h0, 0,1,1, 0, 4'h3);
      chk("R10 in handler", {31'd0, irq_en}, 32'd1);
      op(0,0,0,4'h0,24'h0,32'h0, 0,0,0, 1, 4'h3);
      chk("R8 ignored in handler", {31'd0, s_irq}, 32'd0);
      chk("R8 handler pc", pc, 32'hC);
      // R9: return.
      op(0,0,0,4'h0,24'h0,32'h0, 1,0,0, 0, 4'h5);
      chk("R9 restore_we", {31'd0, s_frw}, 32'd1);
      chk("R9 flags", {28'd0, s_frv}, 32'hA);
      chk("R9 pc", pc, saved_pc);
      chk("R9 state", {30'd0, irq_en, in_handler}, 32'd2);

      // Second round with other flags and a fresh PC.
      op(1,1,0,4'h7,24'h0,32'h0000_2468, 0,0,0, 0, 4'h0);
      op(0,0,0,4'h0,24'h0,32'h0, 1,0,0, 1, 4'h5);
      chk("R7 irq wins over return", {31'd0, s_irq}, 32'd1);
      op(0,0,0,4'h0,24'h0,32'h0, 1,0,0, 0, 4'h0);
      chk("R9 flags second", {28'd0, s_frv}, 32'h5);
      chk("R9 pc second", pc, 32'h0000_2468);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule